// File: doc/BRIEF.md
# Register File with Lane Immediate Set

This block holds the general-purpose integer registers of a 64-bit core: 64 entries of 64 bits each. Two independent combinational read ports serve operand fetch. State changes through two paths that share one clock edge. The first is an ordinary full-width write port. The second is a set port that takes a raw 32-bit instruction word, checks its operation byte, and drops a 16-bit literal into one quarter of the chosen register.

Software builds a full 64-bit constant by issuing up to four set operations, one per quarter. Quarters that a set operation does not name keep their contents. Index 0 is a hardwired zero and index 63 is a hardwired all-ones value. Neither can be overwritten through any path.

Top module: `lane_reg_file`

## Requirements
- R1: While rst_ni is low, every general register (indices 1 to 62) clears to zero and reads back zero after reset is released.
- R2: Index 0 always reads 64'h0 on both read ports. Writes and set operations aimed at it are discarded.
- R3: Index 63 always reads all ones on both read ports. Writes and set operations aimed at it are discarded.
- R4: When wr_en_i is high, wr_data_i replaces all 64 bits of register wr_idx_i at the rising clock edge.
- R5: Reads are combinational. A read of a register in the same cycle as a write to it returns the old value, and the new value appears after the edge.
- R6: The set instruction word has the operation byte in bits 31:24, the target index in bits 23:18, the lane in bits 17:16 and the literal in bits 15:0. When set_en_i is high and the operation byte equals SET_OPCODE (default 8'hA5), the literal is written at the clock edge into lane k of the target, which covers bits 16k+15:16k. Lane 0 is bits 15:0 and lane 3 is bits 63:48.
- R7: A set operation leaves the three lanes it does not name unchanged, so four sets, one per lane, build any 64-bit value.
- R8: A set instruction whose operation byte differs from SET_OPCODE, or one presented with set_en_i low, changes no register.
- R9: If the write port and a valid set operation target the same register in one cycle, the set literal fills its lane and wr_data_i fills the other three lanes.
- R10: The two read ports select and return registers independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 6 | Read port A register index |
| rd_a_data_o | output | 64 | Read port A data |
| rd_b_idx_i | input | 6 | Read port B register index |
| rd_b_data_o | output | 64 | Read port B data |
| wr_en_i | input | 1 | Full-width write enable |
| wr_idx_i | input | 6 | Full-width write register index |
| wr_data_i | input | 64 | Full-width write data |
| set_en_i | input | 1 | Set instruction valid |
| set_instr_i | input | 32 | Set instruction word |

## Verification
The hardest case to reach is the same-cycle collision, in which the write port and a valid set operation name one register. The merge must then take each lane from a different source. The stimulus drives both ports in the same cycle with contrasting patterns, 0xAAAA in every written lane and 0x5555 as the literal. This shows at a glance which source filled each lane. A second hard case is a set that carries a wrong operation byte or arrives with its enable low. The bench reads the targeted register back afterward to show that no lane moved.

// File: rtl/lane_reg_file_pkg.sv
package lane_reg_file_pkg;
  // fixed set-instruction layout
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned IDX_W    = 6;
  localparam int unsigned OPC_MSB  = 31;
  localparam int unsigned OPC_W    = 8;
  localparam int unsigned IDX_MSB  = 23;
  localparam int unsigned LANE_MSB = 17;
  localparam int unsigned LANE_SW  = 2;
  localparam int unsigned LIT_W    = 16;

  typedef struct packed {
    logic               hit;
    logic [IDX_W-1:0]   idx;
    logic [LANE_SW-1:0] lane;
    logic [LIT_W-1:0]   lit;
  } set_op_t;
endpackage

// File: rtl/set_instr_decode.sv
module set_instr_decode
  import lane_reg_file_pkg::*;
#(
  parameter logic [OPC_W-1:0] SET_OPCODE = 8'hA5
) (
  input  logic               set_en_i,
  input  logic [INSTR_W-1:0] instr_i,
  output set_op_t            op_o
);
  always_comb begin
    op_o.hit  = set_en_i && (instr_i[OPC_MSB -: OPC_W] == SET_OPCODE);
    op_o.idx  = instr_i[IDX_MSB -: IDX_W];
    op_o.lane = instr_i[LANE_MSB -: LANE_SW];
    op_o.lit  = instr_i[LIT_W-1:0];
  end
endmodule

// File: rtl/lane_store.sv
module lane_store
  import lane_reg_file_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LANE_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  set_op_t           set_op_i,
  output logic [DATA_W-1:0] mem_o [NUM_REGS]
);
  localparam int unsigned NUM_LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] mem_q [NUM_REGS];

  // entry 0 and the top entry are constants: never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NUM_REGS; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 1; e < NUM_REGS - 1; e++) begin
        for (int l = 0; l < NUM_LANES; l++) begin
          if (set_op_i.hit && set_op_i.idx == IDX_W'(e) && set_op_i.lane == LANE_SW'(l))
            mem_q[e][l*LANE_W +: LANE_W] <= LANE_W'(set_op_i.lit);
          else if (wr_en_i && wr_idx_i == IDX_W'(e))
            mem_q[e][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
        end
      end
    end
  end

  assign mem_o = mem_q;
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import lane_reg_file_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned DATA_W   = 64
) (
  input  logic [DATA_W-1:0] mem_i [NUM_REGS],
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    if (idx_i == '0)                          data_o = '0;
    else if (idx_i == IDX_W'(NUM_REGS - 1))   data_o = '1;
    else                                      data_o = mem_i[idx_i];
  end
endmodule

// File: rtl/lane_reg_file.sv
module lane_reg_file
  import lane_reg_file_pkg::*;
#(
  parameter int unsigned      DATA_W     = 64,
  parameter int unsigned      LANE_W     = 16,
  parameter logic [OPC_W-1:0] SET_OPCODE = 8'hA5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_a_idx_i,
  output logic [DATA_W-1:0]  rd_a_data_o,
  input  logic [IDX_W-1:0]   rd_b_idx_i,
  output logic [DATA_W-1:0]  rd_b_data_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               set_en_i,
  input  logic [INSTR_W-1:0] set_instr_i
);
  localparam int unsigned NUM_REGS = 2 ** IDX_W;

  set_op_t           set_op;
  logic [DATA_W-1:0] mem [NUM_REGS];

  set_instr_decode #(.SET_OPCODE(SET_OPCODE)) u_dec (
    .set_en_i (set_en_i),
    .instr_i  (set_instr_i),
    .op_o     (set_op)
  );

  lane_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .set_op_i  (set_op),
    .mem_o     (mem)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
    .mem_i (mem), .idx_i (rd_a_idx_i), .data_o (rd_a_data_o)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
    .mem_i (mem), .idx_i (rd_b_idx_i), .data_o (rd_b_data_o)
  );
endmodule

// File: rtl/lane_reg_file_chk.sv
module lane_reg_file_chk
  import lane_reg_file_pkg::*;
#(
  parameter int unsigned      DATA_W     = 64,
  parameter int unsigned      LANE_W     = 16,
  parameter logic [OPC_W-1:0] SET_OPCODE = 8'hA5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [IDX_W-1:0]   rd_a_idx_i,
  input logic [DATA_W-1:0]  rd_a_data_o,
  input logic [IDX_W-1:0]   rd_b_idx_i,
  input logic [DATA_W-1:0]  rd_b_data_o,
  input logic               wr_en_i,
  input logic [IDX_W-1:0]   wr_idx_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic               set_en_i,
  input logic [INSTR_W-1:0] set_instr_i
);
  logic              hit;
  logic [IDX_W-1:0]  s_idx;
  logic [1:0]        s_lane;
  logic [LANE_W-1:0] s_lit;
  assign hit    = set_en_i && (set_instr_i[31:24] == SET_OPCODE);
  assign s_idx  = set_instr_i[23:18];
  assign s_lane = set_instr_i[17:16];
  assign s_lit  = set_instr_i[15:0];

  assert_zero_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_idx_i == '0 |-> rd_a_data_o == '0);

  assert_ones_reg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_idx_i == '1 |-> rd_b_data_o == '1);

  assert_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i != '0 && wr_idx_i != '1 && !(hit && s_idx == wr_idx_i))
    |=> (rd_a_idx_i != $past(wr_idx_i)) || (rd_a_data_o == $past(wr_data_i)));

  assert_set_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && s_idx != '0 && s_idx != '1)
    |=> (rd_a_idx_i != $past(s_idx))
        || (LANE_W'(rd_a_data_o >> (LANE_W * $past(s_lane))) == $past(s_lit)));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !hit)
    |=> (rd_a_idx_i != $past(rd_a_idx_i)) || (rd_a_data_o == $past(rd_a_data_o)));
endmodule

bind lane_reg_file lane_reg_file_chk #(
  .DATA_W(DATA_W), .LANE_W(LANE_W), .SET_OPCODE(SET_OPCODE)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
  .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
  .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
  .set_en_i(set_en_i), .set_instr_i(set_instr_i)
);

// File: tb/lane_reg_file_tb_top.sv
`timescale 1ns/1ps
module lane_reg_file_tb_top;
  localparam logic [7:0] OPC = 8'hA5;
  localparam int unsigned NVEC = 15;

  // kind: 0 full write, 1 set, 2 set with wrong opcode
  typedef struct packed {
    logic [1:0]  kind;
    logic [5:0]  idx;
    logic [1:0]  lane;
    logic [63:0] data;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 6'd5,  2'd0, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, 4'd4},  // R4
    '{2'd1, 6'd5,  2'd0, 64'h0000_0000_0000_BEEF, 64'h1111_2222_3333_BEEF, 4'd6},  // R6 lane 0
    '{2'd1, 6'd5,  2'd3, 64'h0000_0000_0000_CAFE, 64'hCAFE_2222_3333_BEEF, 4'd6},  // R6 lane 3
    '{2'd1, 6'd5,  2'd1, 64'h0000_0000_0000_0000, 64'hCAFE_2222_0000_BEEF, 4'd7},  // R7
    '{2'd1, 6'd5,  2'd2, 64'h0000_0000_0000_FFFF, 64'hCAFE_FFFF_0000_BEEF, 4'd7},  // R7
    '{2'd2, 6'd5,  2'd0, 64'h0000_0000_0000_1234, 64'hCAFE_FFFF_0000_BEEF, 4'd8},  // R8
    '{2'd1, 6'd9,  2'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 4'd7},  // R7 build
    '{2'd1, 6'd9,  2'd1, 64'h0000_0000_0000_0002, 64'h0000_0000_0002_0001, 4'd7},
    '{2'd1, 6'd9,  2'd2, 64'h0000_0000_0000_0003, 64'h0000_0003_0002_0001, 4'd7},
    '{2'd1, 6'd9,  2'd3, 64'h0000_0000_0000_0004, 64'h0004_0003_0002_0001, 4'd7},
    '{2'd0, 6'd0,  2'd0, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000, 4'd2},  // R2
    '{2'd1, 6'd0,  2'd2, 64'h0000_0000_0000_7777, 64'h0000_0000_0000_0000, 4'd2},  // R2
    '{2'd1, 6'd63, 2'd0, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 4'd3},  // R3
    '{2'd0, 6'd63, 2'd0, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 4'd3},  // R3
    '{2'd0, 6'd62, 2'd0, 64'hDEAD_0000_BEEF_0001, 64'hDEAD_0000_BEEF_0001, 4'd4}   // R4 top general
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, set_en = 1'b0;
  logic [31:0] set_instr = '0;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  lane_reg_file dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .set_en_i(set_en), .set_instr_i(set_instr)
  );

  function automatic logic [31:0] mk_set(input logic [7:0] opc, input logic [5:0] idx,
                                         input logic [1:0] lane, input logic [15:0] lit);
    return {opc, idx, lane, lit};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; set_en = 1'b0; set_instr = '0;
  endtask

  // present inputs at negedge, let the edge pass, release just after it
  task automatic cycle();
    @(posedge clk); #1; idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    rd_a_idx = 6'd5; rd_b_idx = 6'd62; #1;
    check("R1", rd_a_data, 64'h0);
    check("R1", rd_b_data, 64'h0);

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      case (VECS[k].kind)
        2'd0: begin wr_en = 1'b1; wr_idx = VECS[k].idx; wr_data = VECS[k].data; end
        2'd1: begin set_en = 1'b1;
                set_instr = mk_set(OPC, VECS[k].idx, VECS[k].lane, VECS[k].data[15:0]); end
        default: begin set_en = 1'b1;
                set_instr = mk_set(8'h5A, VECS[k].idx, VECS[k].lane, VECS[k].data[15:0]); end
      endcase
      cycle();
      rd_a_idx = VECS[k].idx; #1;
      check($sformatf("R%0d vec%0d", VECS[k].req, k), rd_a_data, VECS[k].exp);
    end

    // R8: valid opcode but set_en low
    @(negedge clk);
    set_instr = mk_set(OPC, 6'd9, 2'd0, 16'hFFFF);
    cycle();
    rd_a_idx = 6'd9; #1;
    check("R8 enable low", rd_a_data, 64'h0004_0003_0002_0001);

    // R5: same-cycle read returns old value, new after edge
    @(negedge clk);
    rd_a_idx = 6'd7; wr_en = 1'b1; wr_idx = 6'd7; wr_data = 64'h0123_4567_89AB_CDEF; #1;
    check("R5 old", rd_a_data, 64'h0);
    cycle(); #1;
    check("R5 new", rd_a_data, 64'h0123_4567_89AB_CDEF);

    // R9: collision, set lane 2 wins, write fills rest
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd10; wr_data = 64'hAAAA_AAAA_AAAA_AAAA;
    set_en = 1'b1; set_instr = mk_set(OPC, 6'd10, 2'd2, 16'h5555);
    cycle();
    rd_a_idx = 6'd10; #1;
    check("R9", rd_a_data, 64'hAAAA_5555_AAAA_AAAA);

    // R10: both ports, different registers, same cycle
    rd_a_idx = 6'd9; rd_b_idx = 6'd5; #1;
    check("R10 port a", rd_a_data, 64'h0004_0003_0002_0001);
    check("R10 port b", rd_b_data, 64'hCAFE_FFFF_0000_BEEF);
    rd_a_idx = 6'd63; rd_b_idx = 6'd0; #1;
    check("R3 port a", rd_a_data, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R2 port b", rd_b_data, 64'h0);

    // R1: reset again clears written registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_a_idx = 6'd9; rd_b_idx = 6'd10; #1;
    check("R1 again", rd_a_data, 64'h0);
    check("R1 again", rd_b_data, 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule